// File: doc/BRIEF.md
# Page Access Fault Checker

This block sits after address translation and judges whether a memory access is allowed by the attributes of the page that was found. For each access it receives the page's present flag, the effective writable and user attributes, the kind of access (read, write or instruction fetch), the current privilege level and the virtual address. When the access is not allowed it raises a one-cycle fault indication carrying the page-fault exception vector and a 32-bit error code. It also captures the offending virtual address in a fault-address register that software reads afterwards.

The decision is registered: an access presented with `chk_valid` high in one cycle produces its result on the outputs after the next rising clock edge. The error code and the fault address hold their values until the next fault. The table walk that produces the attributes and the delivery of the exception are handled elsewhere.

Top module: `pg_fault_chk`

## Requirements
- R1: An access to a present page that its attributes permit raises no fault: `flt_raise` stays 0 after the edge that samples it.
- R2: An access to a page with `pg_present` = 0 faults whatever its other attributes, and error-code bit 0 is 0; bits 1 and 2 still describe the access.
- R3: A user-level write (`cpl` = 3, `acc_kind` = 2'b01) to a present page with `pg_writable` = 0 faults with error-code bits 0 and 1 both set.
- R4: A supervisor-level write (`cpl` = 0, 1 or 2) to a present read-only page raises no fault.
- R5: A user-level read, write or fetch to a present page with `pg_user` = 0 faults with error-code bits 0 and 2 both set.
- R6: Error-code bit 1 is 1 only for a write; read (`acc_kind` = 2'b00), fetch (2'b10) and the unused value 2'b11 give 0. Bit 2 is 1 exactly when `cpl` = 3.
- R7: `flt_raise` is high for one cycle, the cycle after a faulting access is sampled with `chk_valid` = 1; while it is high `flt_vector` = 8'h0E, otherwise 8'h00. With `chk_valid` = 0 no fault is raised.
- R8: Error-code bits 31 down to 3 are always 0.
- R9: On a fault, `flt_addr` takes the access's `vaddr` and `flt_code` the new code; a non-faulting or idle cycle leaves both unchanged.
- R10: After reset `flt_raise`, `flt_vector`, `flt_code` and `flt_addr` are all 0.

Inputs are sampled on the rising edge of `clk`; `rst_n` is asynchronous, active low, and its release is synchronised inside the block, so the first access should follow release by at least two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | An access is presented this cycle |
| vaddr | input | 32 | Virtual address of the access |
| pg_present | input | 1 | Page present flag |
| pg_writable | input | 1 | Effective writable attribute |
| pg_user | input | 1 | Effective user-accessible attribute |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 treated as read |
| cpl | input | 2 | Current privilege level, 3 is user |
| flt_raise | output | 1 | Page fault raised (one-cycle pulse) |
| flt_vector | output | 8 | Exception vector, 8'h0E during a fault, else 0 |
| flt_code | output | 32 | Error code of the most recent fault |
| flt_addr | output | 32 | Fault-address register |

## Verification
On every cycle the assertions check that reserved code bits stay zero, that the vector follows the raise pulse, that the fault-address and code registers move only on a fault and then hold the sampled address, and that not-present, user-on-supervisor-page and supervisor-write-to-read-only accesses get the outcome the requirements give. The exact code value for each mix of access kind, privilege level and attributes, the treatment of fetch and the unused access kind as reads, and the survival of an earlier address through later permitted accesses are shown only by the bench's directed scenarios.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  localparam int unsigned CODE_BIT_PROT = 0;
  localparam int unsigned CODE_BIT_WR   = 1;
  localparam int unsigned CODE_BIT_USER = 2;

endpackage

// File: rtl/pfc_judge.sv
module pfc_judge
  import pfc_pkg::*;
#(
  parameter int unsigned       CPL_W    = 2,
  parameter logic [CPL_W-1:0]  USER_CPL = '1
) (
  input  logic             valid,
  input  logic             present,
  input  logic             writable,
  input  logic             user_ok,
  input  logic [1:0]       kind,
  input  logic [CPL_W-1:0] cpl,
  output logic             fault,
  output logic             is_write,
  output logic             user_mode,
  output logic             prot
);

  logic wr_violation;
  logic priv_violation;

  always_comb begin
    is_write       = (kind == ACC_WRITE);
    user_mode      = (cpl == USER_CPL);
    wr_violation   = is_write && !writable && user_mode;
    priv_violation = user_mode && !user_ok;
    prot           = present;
    fault          = valid && (!present || wr_violation || priv_violation);
  end

endmodule

// File: rtl/pfc_code_build.sv
module pfc_code_build
  import pfc_pkg::*;
#(
  parameter int unsigned CODE_W = 32
) (
  input  logic              prot,
  input  logic              is_write,
  input  logic              user_mode,
  output logic [CODE_W-1:0] code
);

  always_comb begin
    code                = '0;
    code[CODE_BIT_PROT] = prot;
    code[CODE_BIT_WR]   = is_write;
    code[CODE_BIT_USER] = user_mode;
  end

endmodule

// File: rtl/pfc_hold_reg.sv
module pfc_hold_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/pg_fault_chk.sv
module pg_fault_chk
  import pfc_pkg::*;
#(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned CODE_W  = 32,
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned CPL_W   = 2,
  parameter logic [VEC_W-1:0] PF_VECTOR = 8'h0E,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              pg_present,
  input  logic              pg_writable,
  input  logic              pg_user,
  input  logic [1:0]        acc_kind,
  input  logic [CPL_W-1:0]  cpl,
  output logic              flt_raise,
  output logic [VEC_W-1:0]  flt_vector,
  output logic [CODE_W-1:0] flt_code,
  output logic [VA_W-1:0]   flt_addr
);

  localparam logic [CPL_W-1:0] USER_CPL = '1;

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC_STAGES-1];

  logic              fault_c;
  logic              is_write_c;
  logic              user_mode_c;
  logic              prot_c;
  logic [CODE_W-1:0] code_c;

  pfc_judge #(
    .CPL_W    (CPL_W),
    .USER_CPL (USER_CPL)
  ) u_judge (
    .valid     (chk_valid),
    .present   (pg_present),
    .writable  (pg_writable),
    .user_ok   (pg_user),
    .kind      (acc_kind),
    .cpl       (cpl),
    .fault     (fault_c),
    .is_write  (is_write_c),
    .user_mode (user_mode_c),
    .prot      (prot_c)
  );

  pfc_code_build #(
    .CODE_W (CODE_W)
  ) u_code (
    .prot      (prot_c),
    .is_write  (is_write_c),
    .user_mode (user_mode_c),
    .code      (code_c)
  );

  pfc_hold_reg #(.W(CODE_W)) u_code_reg (
    .clk   (clk),
    .rst_n (rst_q_n),
    .en    (fault_c),
    .d     (code_c),
    .q     (flt_code)
  );

  pfc_hold_reg #(.W(VA_W)) u_addr_reg (
    .clk   (clk),
    .rst_n (rst_q_n),
    .en    (fault_c),
    .d     (vaddr),
    .q     (flt_addr)
  );

  logic raise_q;
  logic raise_nxt;

  always_comb raise_nxt = fault_c;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) raise_q <= 1'b0;
    else          raise_q <= raise_nxt;
  end

  assign flt_raise  = raise_q;
  assign flt_vector = raise_q ? PF_VECTOR : '0;

endmodule

// File: rtl/pfc_sva.sv
module pfc_sva #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned CODE_W = 32,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned CPL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chk_valid,
  input logic [VA_W-1:0]   vaddr,
  input logic              pg_present,
  input logic              pg_writable,
  input logic              pg_user,
  input logic [1:0]        acc_kind,
  input logic [CPL_W-1:0]  cpl,
  input logic              flt_raise,
  input logic [VEC_W-1:0]  flt_vector,
  input logic [CODE_W-1:0] flt_code,
  input logic [VA_W-1:0]   flt_addr
);

  localparam logic [CPL_W-1:0] UCPL = '1;

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flt_code[CODE_W-1:3] == '0);

  a_r7_vector_on_raise: assert property (@(posedge clk) disable iff (!rst_n)
    flt_raise |-> flt_vector == VEC_W'(8'h0E));

  a_r7_vector_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_raise |-> flt_vector == '0);

  a_r7_raise_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !flt_raise);

  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_raise |-> $stable(flt_addr) && $stable(flt_code));

  a_r9_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> !flt_raise || flt_addr == $past(vaddr));

  a_r2_not_present: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !pg_present |=> flt_raise && !flt_code[0]);

  a_r5_user_on_sup: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && pg_present && !pg_user && cpl == UCPL
    |=> flt_raise && flt_code[0] && flt_code[2]);

  a_r4_sup_write_ro: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && pg_present && !pg_writable && acc_kind == 2'b01 && cpl != UCPL
    && pg_user |=> !flt_raise);

endmodule

bind pg_fault_chk pfc_sva #(
  .VA_W   (VA_W),
  .CODE_W (CODE_W),
  .VEC_W  (VEC_W),
  .CPL_W  (CPL_W)
) u_pfc_sva (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .chk_valid   (chk_valid),
  .vaddr       (vaddr),
  .pg_present  (pg_present),
  .pg_writable (pg_writable),
  .pg_user     (pg_user),
  .acc_kind    (acc_kind),
  .cpl         (cpl),
  .flt_raise   (flt_raise),
  .flt_vector  (flt_vector),
  .flt_code    (flt_code),
  .flt_addr    (flt_addr)
);

// File: tb/test_pg_fault_chk.sv
module test_pg_fault_chk;

  logic        clk;
  logic        rst_n;
  logic        chk_valid;
  logic [31:0] vaddr;
  logic        pg_present;
  logic        pg_writable;
  logic        pg_user;
  logic [1:0]  acc_kind;
  logic [1:0]  cpl;
  logic        flt_raise;
  logic [7:0]  flt_vector;
  logic [31:0] flt_code;
  logic [31:0] flt_addr;

  int checks;
  int errors;
  logic [31:0] exp_addr;
  logic [31:0] exp_code;

  pg_fault_chk i_pg_fault_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_valid   (chk_valid),
    .vaddr       (vaddr),
    .pg_present  (pg_present),
    .pg_writable (pg_writable),
    .pg_user     (pg_user),
    .acc_kind    (acc_kind),
    .cpl         (cpl),
    .flt_raise   (flt_raise),
    .flt_vector  (flt_vector),
    .flt_code    (flt_code),
    .flt_addr    (flt_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one access, then compare outputs on the following falling edge
  task automatic access(input string req, input logic [31:0] va,
                        input logic p, input logic w, input logic u,
                        input logic [1:0] k, input logic [1:0] lvl,
                        input logic exp_fault);
    logic umode;
    logic [31:0] code;
    @(negedge clk);
    chk_valid = 1'b1; vaddr = va; pg_present = p; pg_writable = w;
    pg_user = u; acc_kind = k; cpl = lvl;
    @(negedge clk);
    chk_valid = 1'b0;
    umode = (lvl == 2'd3);
    code  = {29'd0, umode, (k == 2'b01), p};
    if (exp_fault) begin
      exp_addr = va;
      exp_code = code;
    end
    chk(req, "raise", {31'd0, flt_raise}, {31'd0, exp_fault});
    chk(req, "vector", {24'd0, flt_vector}, exp_fault ? 32'h0E : 32'h0);
    chk(req, "code", flt_code, exp_code);
    chk(req, "addr", flt_addr, exp_addr);
  endtask

  task automatic t_reset();
    chk("R10", "raise", {31'd0, flt_raise}, 32'd0);
    chk("R10", "vector", {24'd0, flt_vector}, 32'd0);
    chk("R10", "code", flt_code, 32'd0);
    chk("R10", "addr", flt_addr, 32'd0);
  endtask

  task automatic t_permitted();
    access("R1", 32'h0000_1000, 1, 1, 1, 2'b00, 2'd3, 0);
    access("R1", 32'h0000_2004, 1, 1, 1, 2'b01, 2'd3, 0);
    access("R1", 32'h0000_3008, 1, 0, 0, 2'b10, 2'd0, 0);
    access("R1", 32'h0000_400C, 1, 0, 1, 2'b00, 2'd3, 0);
  endtask

  task automatic t_not_present();
    access("R2", 32'hC000_0123, 0, 1, 1, 2'b00, 2'd0, 1);
    access("R2", 32'hC000_1234, 0, 1, 1, 2'b01, 2'd3, 1);
    access("R2", 32'hC000_2345, 0, 0, 0, 2'b10, 2'd3, 1);
  endtask

  task automatic t_user_ro_write();
    access("R3", 32'h0804_8ABC, 1, 0, 1, 2'b01, 2'd3, 1);
  endtask

  task automatic t_sup_ro_write();
    access("R4", 32'h0010_0000, 1, 0, 1, 2'b01, 2'd0, 0);
    access("R4", 32'h0010_1000, 1, 0, 0, 2'b01, 2'd2, 0);
    access("R4", 32'h0010_2000, 1, 0, 1, 2'b01, 2'd1, 0);
  endtask

  task automatic t_user_on_sup();
    access("R5", 32'hF000_0010, 1, 1, 0, 2'b00, 2'd3, 1);
    access("R5", 32'hF000_0020, 1, 1, 0, 2'b01, 2'd3, 1);
    access("R5", 32'hF000_0030, 1, 1, 0, 2'b10, 2'd3, 1);
    access("R5", 32'hF000_0040, 1, 0, 0, 2'b01, 2'd3, 1);
  endtask

  task automatic t_kind_bits();
    // R6: fetch and the unused kind report as reads
    access("R6", 32'h1111_0000, 0, 1, 1, 2'b10, 2'd3, 1);
    chk("R6", "fetch code", flt_code, 32'h0000_0004);
    access("R6", 32'h2222_0000, 0, 1, 1, 2'b11, 2'd2, 1);
    chk("R6", "rsvd kind code", flt_code, 32'h0000_0000);
    access("R6", 32'h3333_0000, 1, 0, 1, 2'b01, 2'd3, 1);
    chk("R6", "user write code", flt_code, 32'h0000_0007);
  endtask

  task automatic t_idle_and_hold();
    // R7: faulting attributes with chk_valid low raise nothing
    @(negedge clk);
    chk_valid = 1'b0; vaddr = 32'hDEAD_BEEF; pg_present = 1'b0;
    acc_kind = 2'b01; cpl = 2'd3;
    @(negedge clk);
    chk("R7", "idle raise", {31'd0, flt_raise}, 32'd0);
    chk("R9", "idle addr", flt_addr, exp_addr);
    // R9: later permitted access keeps address and code
    access("R9", 32'h5555_5000, 1, 1, 1, 2'b01, 2'd3, 0);
    // R7: pulse lasts one cycle
    access("R7", 32'h6666_6000, 0, 0, 0, 2'b00, 2'd0, 1);
    @(negedge clk);
    chk("R7", "pulse end", {31'd0, flt_raise}, 32'd0);
    chk("R8", "reserved bits", {3'd0, flt_code[31:3]}, 32'd0);
  endtask

  task automatic t_back_to_back();
    // R9: consecutive faults each capture their own address
    @(negedge clk);
    chk_valid = 1'b1; vaddr = 32'hAAAA_0001; pg_present = 1'b0;
    acc_kind = 2'b00; cpl = 2'd0;
    @(negedge clk);
    chk("R9", "b2b first addr", flt_addr, 32'hAAAA_0001);
    vaddr = 32'hBBBB_0002; pg_present = 1'b1; pg_user = 1'b0; cpl = 2'd3;
    @(negedge clk);
    chk_valid = 1'b0;
    chk("R9", "b2b second addr", flt_addr, 32'hBBBB_0002);
    chk("R5", "b2b second code", flt_code, 32'h0000_0005);
    chk("R7", "b2b raise held", {31'd0, flt_raise}, 32'd1);
    exp_addr = 32'hBBBB_0002;
    exp_code = 32'h0000_0005;
  endtask

  logic done;

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    exp_addr = '0; exp_code = '0;
    rst_n = 1'b0; chk_valid = 1'b0; vaddr = '0; pg_present = 1'b0;
    pg_writable = 1'b0; pg_user = 1'b0; acc_kind = 2'b00; cpl = 2'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_permitted();
    t_not_present();
    t_user_ro_write();
    t_sup_ro_write();
    t_user_on_sup();
    t_kind_bits();
    t_idle_and_hold();
    t_back_to_back();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule